// File: doc/BRIEF.md
# Inverted-Timing Pixel Time Digitiser

This block is the digital half of one time-to-digital pixel in a photon-timing array. It runs from a clock that stands in for the pixel's own gated ring oscillator, one clock per oscillator period. The ring's tap levels arrive as a sampled phase vector. The pixel stays dark until a photon event arrives, and it does not count before then. From the first event onward it enables the oscillator, through an enable output, and counts whole periods. A stop edge shared by every pixel in the array ends the count. At the stop edge the block captures the ring's tap state and turns it into a fine code worth one 100 ps bin per step. The coarse count is eight fine bins, or 800 ps.

Because the count runs from the event to a common stop, the raw interval is measured backwards. The block subtracts it from full scale so that the word it reports is an arrival time in 100 ps bins. Full scale is 128 coarse periods (102.4 ns). Each frame produces one result, whether the pixel saw a hit or not. The result leaves on a valid/ready port. The word is held unchanged while the receiver stalls. The pixel accepts no new frame until the result has been taken and the pixel has been armed again.

Top module: `tdc_pixel`

## Requirements
- R1: After reset the pixel is idle: `res_valid_o`, `osc_en_o`, `res_hit_o` and `res_ovf_o` are 0 and `res_time_o` is 0.
- R2: In the idle state, `stop_i` and `event_i` have no effect. No result appears and the oscillator stays off. Only `arm_i` moves the pixel to the armed state.
- R3: `osc_en_o` goes high in the cycle after the clock edge that accepts an event in the armed state. It stays high until the edge that samples `stop_i`, and it is low at every other time.
- R4: The coarse count C equals k-1, where k is the number of clock edges from the event edge to the stop edge. The count saturates at 127.
- R5: Stage i is taken as high when tap `phase_i[i]` is 1 and its complement tap `phase_i[4+i]` is 0. Let n be the number of high stages. The fine code F is n when stage 0 is high. Otherwise F is 8-n, or 0 when n is 0.
- R6: On a hit the result has `res_hit_o`=1 and `res_time_o` = 1024 - (8*C + F).
- R7: When k >= 129 the count overflows. The result then has `res_ovf_o`=1, `res_hit_o`=1 and `res_time_o`=1.
- R8: A stop seen in the armed state with no earlier event gives a no-hit result, with valid=1, hit=0, ovf=0 and time=0. This also applies when the event and the stop arrive in the same cycle.
- R9: Only the first event of a frame is timed. Further events and arm pulses seen while counting do not change the result.
- R10: Once a stop has been sampled, `res_valid_o` rises in the next cycle. The result fields stay stable until a cycle with `res_ready_i`=1. After that cycle `res_valid_o` is 0 and the pixel is idle.
- R11: While a result is pending, `arm_i`, `event_i` and `stop_i` are ignored. The result does not change and the oscillator stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock, one edge per ring period |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arms the pixel for a new frame (idle state only) |
| event_i | input | 1 | Photon event from the detector front end |
| stop_i | input | 1 | Stop edge shared by every pixel in the array |
| phase_i | input | 8 | Ring taps: bits 3:0 true rails, bits 7:4 complement rails |
| osc_en_o | output | 1 | Enables the in-pixel ring oscillator |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Receiver accepts the result |
| res_hit_o | output | 1 | An event was timed this frame |
| res_ovf_o | output | 1 | Coarse count saturated |
| res_time_o | output | 11 | Arrival time in 100 ps bins |

## Verification
The bench sweeps the event-to-stop gap through every coarse value and past saturation. A counter that lost the minus-one alignment, or that wrapped instead of saturating, would report arrival times one period off or near full scale. A sweep over all 256 tap patterns at one fixed gap exposes a decoder that ignores the complement rails or mirrors the second half of the period. Targeted frames cover the cases where the event and the stop coincide, where a second event arrives mid-count, where a stop arrives without arm, and where the receiver stalls for a long time. A design that restarted on a later event, started a frame without arm, or let a stalled word change would show it at the output.

// File: rtl/tdc_pixel_pkg.sv
package tdc_pixel_pkg;
  typedef enum logic [1:0] {
    PX_IDLE  = 2'd0,
    PX_ARMED = 2'd1,
    PX_RUN   = 2'd2,
    PX_HOLD  = 2'd3
  } px_state_e;
endpackage

// File: rtl/tdc_pixel_ctrl.sv
module tdc_pixel_ctrl
  import tdc_pixel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      arm_i,
  input  logic      event_i,
  input  logic      stop_i,
  input  logic      ready_i,
  output px_state_e state_o,
  output logic      cnt_clr_o,
  output logic      cnt_en_o,
  output logic      cap_hit_o,
  output logic      cap_miss_o
);
  px_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    cnt_clr_o  = 1'b0;
    cnt_en_o   = 1'b0;
    cap_hit_o  = 1'b0;
    cap_miss_o = 1'b0;
    case (state_q)
      PX_IDLE: if (arm_i) state_d = PX_ARMED;
      PX_ARMED: begin
        // the shared stop wins over an event in the same cycle
        if (stop_i) begin
          cap_miss_o = 1'b1;
          state_d    = PX_HOLD;
        end else if (event_i) begin
          cnt_clr_o = 1'b1;
          state_d   = PX_RUN;
        end
      end
      PX_RUN: begin
        if (stop_i) begin
          cap_hit_o = 1'b1;
          state_d   = PX_HOLD;
        end else begin
          cnt_en_o = 1'b1;
        end
      end
      PX_HOLD: if (ready_i) state_d = PX_IDLE;
      default: state_d = PX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PX_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/tdc_coarse_cnt.sv
module tdc_coarse_cnt #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (en_i) begin
      if (cnt_o == TOP) ovf_o <= 1'b1;
      else              cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/tdc_phase_dec.sv
module tdc_phase_dec #(
  parameter int STAGES = 4,
  parameter int FINE_W = $clog2(2 * STAGES + 1)
) (
  input  logic [2*STAGES-1:0] phase_i,
  output logic [FINE_W-1:0]   fine_o
);
  logic [STAGES-1:0] stage_hi;
  logic [FINE_W-1:0] n_hi;

  // a stage counts as high only when its two rails disagree the right way
  for (genvar g = 0; g < STAGES; g++) begin : g_rail
    assign stage_hi[g] = phase_i[g] & ~phase_i[STAGES + g];
  end

  always_comb begin
    n_hi = '0;
    for (int i = 0; i < STAGES; i++) n_hi = n_hi + FINE_W'(stage_hi[i]);
  end

  always_comb begin
    if (stage_hi[0])       fine_o = n_hi;
    else if (n_hi == '0)   fine_o = '0;
    else                   fine_o = FINE_W'(2 * STAGES) - n_hi;
  end
endmodule

// File: rtl/tdc_result_reg.sv
module tdc_result_reg #(
  parameter int COARSE_W  = 7,
  parameter int FINE_BINS = 8,
  parameter int FINE_W    = 4,
  parameter int TIME_W    = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_hit_i,
  input  logic                cap_miss_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic                ovf_i,
  input  logic [FINE_W-1:0]   fine_i,
  output logic                hit_o,
  output logic                ovf_o,
  output logic [TIME_W-1:0]   time_o
);
  localparam int FULL = (2 ** COARSE_W) * FINE_BINS;

  logic [TIME_W-1:0] span;
  logic [TIME_W-1:0] arrival;

  always_comb begin
    if (ovf_i) span = TIME_W'(FULL - 1);
    else       span = (TIME_W'(coarse_i) * TIME_W'(FINE_BINS)) + TIME_W'(fine_i);
    arrival = TIME_W'(FULL) - span;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_o  <= 1'b0;
      ovf_o  <= 1'b0;
      time_o <= '0;
    end else if (cap_hit_i) begin
      hit_o  <= 1'b1;
      ovf_o  <= ovf_i;
      time_o <= arrival;
    end else if (cap_miss_i) begin
      hit_o  <= 1'b0;
      ovf_o  <= 1'b0;
      time_o <= '0;
    end
  end
endmodule

// File: rtl/tdc_pixel.sv
module tdc_pixel
  import tdc_pixel_pkg::*;
#(
  parameter int COARSE_W = 7,
  parameter int STAGES   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm_i,
  input  logic                   event_i,
  input  logic                   stop_i,
  input  logic [2*STAGES-1:0]    phase_i,
  output logic                   osc_en_o,
  output logic                   res_valid_o,
  input  logic                   res_ready_i,
  output logic                   res_hit_o,
  output logic                   res_ovf_o,
  output logic [$clog2((2**COARSE_W)*2*STAGES):0] res_time_o
);
  localparam int FINE_BINS = 2 * STAGES;
  localparam int FINE_W    = $clog2(FINE_BINS + 1);
  localparam int TIME_W    = $clog2((2 ** COARSE_W) * FINE_BINS) + 1;

  px_state_e           state;
  logic                cnt_clr, cnt_en, cap_hit, cap_miss;
  logic [COARSE_W-1:0] coarse;
  logic                cnt_ovf;
  logic [FINE_W-1:0]   fine;

  tdc_pixel_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm_i),
    .event_i   (event_i),
    .stop_i    (stop_i),
    .ready_i   (res_ready_i),
    .state_o   (state),
    .cnt_clr_o (cnt_clr),
    .cnt_en_o  (cnt_en),
    .cap_hit_o (cap_hit),
    .cap_miss_o(cap_miss)
  );

  tdc_coarse_cnt #(.WIDTH(COARSE_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr_i(cnt_clr),
    .en_i (cnt_en),
    .cnt_o(coarse),
    .ovf_o(cnt_ovf)
  );

  tdc_phase_dec #(.STAGES(STAGES), .FINE_W(FINE_W)) u_dec (
    .phase_i(phase_i),
    .fine_o (fine)
  );

  tdc_result_reg #(
    .COARSE_W (COARSE_W),
    .FINE_BINS(FINE_BINS),
    .FINE_W   (FINE_W),
    .TIME_W   (TIME_W)
  ) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_hit_i (cap_hit),
    .cap_miss_i(cap_miss),
    .coarse_i  (coarse),
    .ovf_i     (cnt_ovf),
    .fine_i    (fine),
    .hit_o     (res_hit_o),
    .ovf_o     (res_ovf_o),
    .time_o    (res_time_o)
  );

  assign osc_en_o    = (state == PX_RUN);
  assign res_valid_o = (state == PX_HOLD);
endmodule

// File: rtl/tdc_pixel_chk.sv
module tdc_pixel_chk #(
  parameter int TIME_W = 11,
  parameter int FS     = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              event_i,
  input logic              stop_i,
  input logic              osc_en_o,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic              res_hit_o,
  input logic              res_ovf_o,
  input logic [TIME_W-1:0] res_time_o
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_time_o) && $stable(res_hit_o) && $stable(res_ovf_o))); // R10
  AST_ACCEPT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_ready_i) |=> !res_valid_o); // R10
  AST_NOHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_hit_o) |-> (res_time_o == '0 && !res_ovf_o)); // R8
  AST_HIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_hit_o) |-> (res_time_o >= TIME_W'(1) && res_time_o <= TIME_W'(FS))); // R6
  AST_OVF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_ovf_o) |-> (res_hit_o && res_time_o == TIME_W'(1))); // R7
  AST_OSC_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en_o) |-> $past(event_i)); // R3
  AST_OSC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> !osc_en_o); // R11
  AST_VALID_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid_o) |-> $past(stop_i)); // R10
endmodule

bind tdc_pixel tdc_pixel_chk #(
  .TIME_W(TIME_W),
  .FS    ((2 ** COARSE_W) * FINE_BINS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .event_i    (event_i),
  .stop_i     (stop_i),
  .osc_en_o   (osc_en_o),
  .res_valid_o(res_valid_o),
  .res_ready_i(res_ready_i),
  .res_hit_o  (res_hit_o),
  .res_ovf_o  (res_ovf_o),
  .res_time_o (res_time_o)
);

// File: tb/sim_tdc_pixel.sv
module sim_tdc_pixel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0, ev = 1'b0, stp = 1'b0, rdy = 1'b0;
  logic [7:0]  ph = 8'h0;
  logic        osc_en, vld, hit, ovf;
  logic [10:0] tword;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  tdc_pixel u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .event_i(ev), .stop_i(stp),
    .phase_i(ph), .osc_en_o(osc_en), .res_valid_o(vld), .res_ready_i(rdy),
    .res_hit_o(hit), .res_ovf_o(ovf), .res_time_o(tword)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fine_of(logic [7:0] t);
    logic [3:0] r = t[3:0] & ~t[7:4];
    int n = $countones(r);
    if (r[0]) return n;
    if (n == 0) return 0;
    return 8 - n;
  endfunction

  function automatic logic [7:0] ring(int v);
    logic [3:0] s = (v <= 4) ? 4'((1 << v) - 1) : 4'((4'hf << (v - 4)) & 4'hf);
    return {~s, s};
  endfunction

  task automatic take();
    rdy = 1'b1;
    @(negedge clk) rdy = 1'b0;
    chk("R10 valid after accept", int'(vld), 0);
  endtask

  // event at edge t, stop at edge t+k
  task automatic hit_frame(int k, logic [7:0] taps, bit noise, string tag);
    int exp_c, exp_t;
    bit exp_o;
    @(negedge clk) arm = 1'b1;
    @(negedge clk) begin arm = 1'b0; ev = 1'b1; end
    @(negedge clk) ev = 1'b0;
    if (k > 1) chk("R3 osc enabled while counting", int'(osc_en), 1);
    for (int i = 1; i < k; i++) begin
      ev  = noise && (i == 1);
      arm = noise && (i == 2);
      @(negedge clk);
    end
    ev = 1'b0; arm = 1'b0;
    stp = 1'b1; ph = taps;
    @(negedge clk) stp = 1'b0;
    exp_o = (k >= 129);
    exp_c = exp_o ? 127 : k - 1;
    exp_t = exp_o ? 1 : 1024 - (exp_c * 8 + fine_of(taps));
    chk({tag, " valid"}, int'(vld), 1);
    chk({tag, " hit"}, int'(hit), 1);
    chk({tag, " ovf"}, int'(ovf), int'(exp_o));
    chk({tag, " time"}, int'(tword), exp_t);
    chk("R3 osc off after stop", int'(osc_en), 0);
    take();
  endtask

  task automatic miss_frame(bit same, string tag);
    @(negedge clk) arm = 1'b1;
    @(negedge clk) begin arm = 1'b0; stp = 1'b1; ev = same; end
    @(negedge clk) begin stp = 1'b0; ev = 1'b0; end
    chk({tag, " valid"}, int'(vld), 1);
    chk({tag, " hit"}, int'(hit), 0);
    chk({tag, " ovf"}, int'(ovf), 0);
    chk({tag, " time"}, int'(tword), 0);
    chk("R3 osc stays off", int'(osc_en), 0);
    take();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", int'(vld), 0);
    chk("R1 osc", int'(osc_en), 0);
    chk("R1 hit", int'(hit), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 time", int'(tword), 0);

    // R2: stop and event without arm do nothing
    stp = 1'b1;
    @(negedge clk) begin stp = 1'b0; ev = 1'b1; end
    @(negedge clk) ev = 1'b0;
    chk("R2 no result without arm", int'(vld), 0);
    chk("R2 osc off without arm", int'(osc_en), 0);
    @(negedge clk);
    chk("R2 still idle", int'(vld), 0);

    // R4 R6 R7: every coarse gap plus saturation
    for (int k = 1; k <= 132; k++)
      hit_frame(k, ring(k % 8), 1'b0, (k >= 129) ? "R7 overflow" : "R4 R6 gap");

    // R5: known ring states decode to their index
    for (int v = 0; v < 8; v++) hit_frame(4, ring(v), 1'b0, "R5 ring state");
    for (int v = 0; v < 8; v++) chk("R5 decode", fine_of(ring(v)), v);
    // R5: every tap pattern, including rail bubbles
    for (int p = 0; p < 256; p++) hit_frame(4, 8'(p), 1'b0, "R5 taps");

    // R9: later events and arm pulses while counting
    hit_frame(10, ring(3), 1'b1, "R9 first event only");
    hit_frame(140, ring(6), 1'b1, "R9 noisy overflow");

    // R8: no event, and event coinciding with stop
    miss_frame(1'b0, "R8 no event");
    miss_frame(1'b1, "R8 same cycle");

    // R10 R11: long stall with noise on every control input
    @(negedge clk) arm = 1'b1;
    @(negedge clk) begin arm = 1'b0; ev = 1'b1; end
    @(negedge clk) ev = 1'b0;
    repeat (4) @(negedge clk);
    stp = 1'b1; ph = ring(2);
    @(negedge clk) stp = 1'b0;
    for (int i = 0; i < 6; i++) begin
      arm = i[0]; ev = ~i[0]; stp = i[1];
      @(negedge clk);
      chk("R10 held valid", int'(vld), 1);
      chk("R11 held time", int'(tword), 1024 - (4 * 8 + 2));
      chk("R11 held hit", int'(hit), 1);
      chk("R11 osc off while pending", int'(osc_en), 0);
    end
    arm = 1'b0; ev = 1'b0; stp = 1'b0;
    take();
    @(negedge clk);
    chk("R10 idle after accept", int'(osc_en), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule